// File: doc/BRIEF.md
# Multi-Rail Supply Fault Latch

This block watches four supply rails (3.3 V, 5 V and two separate 12 V rails) for over-voltage, under-voltage and over-current. Each rail delivers three digital comparator flags, already synchronous to the block clock. A flag counts as a fault only after it has stayed asserted for the qualification time of its own kind. Over-voltage qualifies fastest. Under-voltage takes about forty times longer, and over-current takes longer again.

A qualified fault sets one latch. While the latch is set, the PWM shutdown output is driven high and the power-good permit is driven low. The latch also records which kind of fault and which rail tripped first, and that record does not change until the latch is cleared. Under-voltage and over-current are ignored while the supply-on indication from the sequencer is low. They are also ignored for a blanking window that restarts each time supply-on rises. Over-voltage is never blanked.

All delays are parameters in clock cycles. With the defaults and a 1 MHz sample clock they give 75 µs, 3.2 ms, 20 ms and 75 ms. The clear input stands for the remote request that commands the supply off.

Top module: `rail_fault_latch`

## Requirements
- R1: While reset is asserted, `pwm_off` is 0, `pg_ok` is 1, `fault_kind` is 0 and `fault_rail` is 0.
- R2: An over-voltage flag on any rail that is sampled high on OV_DLY consecutive clock edges sets the latch on the next edge. This holds even if the flag drops after the last of those edges.
- R3: An under-voltage flag on any rail that is sampled high and unblanked on UV_DLY consecutive edges sets the latch on the next edge.
- R4: An over-current flag on any rail that is sampled high and unblanked on OC_DLY consecutive edges sets the latch on the next edge.
- R5: If a flag drops before its count completes, qualification restarts from zero. Two runs of DLY-1 samples separated by a low sample set no fault.
- R6: While the latch is set, `pwm_off` is 1 and `pg_ok` is 0. `fault_kind` is 1 for over-voltage, 2 for under-voltage and 3 for over-current. `fault_rail` is 0 for 3.3 V, 1 for 5 V, 2 for the first 12 V rail and 3 for the second, which is also the bit index of the flag vectors. The latch holds until `clr`.
- R7: The kind and rail of the first fault are kept. Faults that qualify later do not change `fault_kind` or `fault_rail` while the latch is set.
- R8: When several faults qualify on the same edge, over-voltage wins over under-voltage, and under-voltage wins over over-current. Within one kind, the lowest rail index wins.
- R9: `clr` is synchronous. On the edge where it is sampled high, the latch is cleared and `fault_kind` and `fault_rail` return to 0, even if a fault is qualified on that edge. A fault that is still qualified sets the latch again on the first edge after `clr` drops.
- R10: While `supply_on` is low, under-voltage and over-current flags are ignored and their counts are held at zero. Over-voltage stays active.
- R11: After `supply_on` rises, under-voltage and over-current stay blanked on the first BLANK_DLY+1 edges. An under-voltage flag that is held from the rise therefore sets the latch BLANK_DLY+UV_DLY+2 edges after the rise.
- R12: Every rise of `supply_on` restarts the blanking window, even if an earlier window has not yet expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| supply_on | input | 1 | Supply-on indication from the sequencer |
| clr | input | 1 | Synchronous clear of the fault latch |
| ov_flag | input | N_RAILS | Over-voltage comparator flags, one per rail |
| uv_flag | input | N_RAILS | Under-voltage comparator flags, one per rail |
| oc_flag | input | N_RAILS | Over-current comparator flags, one per rail |
| pwm_off | output | 1 | High turns the PWM controller off; high while a fault is latched |
| pg_ok | output | 1 | Power-good permit; low while a fault is latched |
| fault_kind | output | 2 | Kind of the first fault: 0 none, 1 OV, 2 UV, 3 OC |
| fault_rail | output | RAIL_W | Rail index of the first fault |

## Verification
The assertions assume that every flag, `supply_on` and `clr` is a clean signal synchronous to `clk`. They also assume that the delay parameters are at least 1, so that a freshly loaded blanking timer or a counter in progress is never already at its limit. The bench changes all inputs on the falling edge and counts rising edges from that point. With small delays, the sweep visits every kind on every rail. The priority cases are built by staggering start times so that two counts finish on exactly the same edge.

// File: rtl/rfl_pkg.sv
package rfl_pkg;
  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_OV   = 2'd1,
    FK_UV   = 2'd2,
    FK_OC   = 2'd3
  } fault_kind_e;
endpackage

// File: rtl/rfl_qual_timer.sv
module rfl_qual_timer #(
  parameter int unsigned DELAY = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic qualified
);
  localparam int unsigned W = $clog2(DELAY + 1);
  localparam logic [W-1:0] LIMIT = W'(DELAY);

  logic [W-1:0] cnt_q, cnt_d;

  // count consecutive enabled samples, saturate at the limit
  always_comb begin
    cnt_d = cnt_q;
    if (!en)
      cnt_d = '0;
    else if (cnt_q != LIMIT)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign qualified = (cnt_q == LIMIT);

  // R5
  restart_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !qualified);

  // R2
  qual_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qualified |-> $past(en));
endmodule

// File: rtl/rfl_blank_timer.sv
module rfl_blank_timer #(
  parameter int unsigned BLANK = 75000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_on,
  output logic blanked
);
  localparam int unsigned BW = $clog2(BLANK + 1);
  localparam logic [BW-1:0] LOAD = BW'(BLANK);

  logic          on_q;
  logic          rise;
  logic [BW-1:0] tmr_q, tmr_d;

  assign rise = supply_on & ~on_q;

  always_comb begin
    tmr_d = tmr_q;
    if (rise)
      tmr_d = LOAD;
    else if (tmr_q != '0)
      tmr_d = tmr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      tmr_q <= '0;
    end else begin
      on_q  <= supply_on;
      tmr_q <= tmr_d;
    end
  end

  assign blanked = ~supply_on | rise | (tmr_q != '0);

  // R12
  rise_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_on) |=> blanked);

  // R11
  window_stays_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_on && !blanked) |=> (!supply_on || !blanked));
endmodule

// File: rtl/rfl_first_pick.sv
module rfl_first_pick
  import rfl_pkg::*;
#(
  parameter int unsigned N_RAILS = 4,
  localparam int unsigned RAIL_W = $clog2(N_RAILS)
) (
  input  logic [N_RAILS-1:0] ov_q,
  input  logic [N_RAILS-1:0] uv_q,
  input  logic [N_RAILS-1:0] oc_q,
  output logic               any,
  output fault_kind_e        kind,
  output logic [RAIL_W-1:0]  rail
);
  // later assignments win: OC, then UV, then OV; descending rails so index 0 wins
  always_comb begin
    kind = FK_NONE;
    rail = '0;
    for (int i = N_RAILS - 1; i >= 0; i--) begin
      if (oc_q[i]) begin
        kind = FK_OC;
        rail = RAIL_W'(i);
      end
    end
    for (int i = N_RAILS - 1; i >= 0; i--) begin
      if (uv_q[i]) begin
        kind = FK_UV;
        rail = RAIL_W'(i);
      end
    end
    for (int i = N_RAILS - 1; i >= 0; i--) begin
      if (ov_q[i]) begin
        kind = FK_OV;
        rail = RAIL_W'(i);
      end
    end
  end

  assign any = |{ov_q, uv_q, oc_q};
endmodule

// File: rtl/rail_fault_latch.sv
module rail_fault_latch
  import rfl_pkg::*;
#(
  parameter int unsigned N_RAILS   = 4,
  parameter int unsigned OV_DLY    = 75,
  parameter int unsigned UV_DLY    = 3200,
  parameter int unsigned OC_DLY    = 20000,
  parameter int unsigned BLANK_DLY = 75000,
  localparam int unsigned RAIL_W   = $clog2(N_RAILS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               supply_on,
  input  logic               clr,
  input  logic [N_RAILS-1:0] ov_flag,
  input  logic [N_RAILS-1:0] uv_flag,
  input  logic [N_RAILS-1:0] oc_flag,
  output logic               pwm_off,
  output logic               pg_ok,
  output logic [1:0]         fault_kind,
  output logic [RAIL_W-1:0]  fault_rail
);
  // reset: asynchronous assert, synchronous release
  logic rs_meta, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_ns  <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_ns  <= rs_meta;
    end
  end

  logic blanked;
  rfl_blank_timer #(.BLANK(BLANK_DLY)) u_blank (
    .clk       (clk),
    .rst_n     (rst_ns),
    .supply_on (supply_on),
    .blanked   (blanked)
  );

  logic [N_RAILS-1:0] ov_q, uv_q, oc_q;

  for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
    rfl_qual_timer #(.DELAY(OV_DLY)) u_ov (
      .clk (clk), .rst_n (rst_ns), .en (ov_flag[r]), .qualified (ov_q[r]));
    rfl_qual_timer #(.DELAY(UV_DLY)) u_uv (
      .clk (clk), .rst_n (rst_ns), .en (uv_flag[r] & ~blanked), .qualified (uv_q[r]));
    rfl_qual_timer #(.DELAY(OC_DLY)) u_oc (
      .clk (clk), .rst_n (rst_ns), .en (oc_flag[r] & ~blanked), .qualified (oc_q[r]));
  end

  logic              any_q;
  fault_kind_e       pick_kind;
  logic [RAIL_W-1:0] pick_rail;

  rfl_first_pick #(.N_RAILS(N_RAILS)) u_pick (
    .ov_q (ov_q), .uv_q (uv_q), .oc_q (oc_q),
    .any  (any_q), .kind (pick_kind), .rail (pick_rail)
  );

  // fault latch with first-fault record
  logic              lat_q, lat_d;
  fault_kind_e       kind_q, kind_d;
  logic [RAIL_W-1:0] rail_q, rail_d;
  logic              lat_en;

  always_comb begin
    lat_en = clr | (~lat_q & any_q);
    lat_d  = 1'b0;
    kind_d = FK_NONE;
    rail_d = '0;
    if (!clr) begin
      lat_d  = 1'b1;
      kind_d = pick_kind;
      rail_d = pick_rail;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      lat_q  <= 1'b0;
      kind_q <= FK_NONE;
      rail_q <= '0;
    end else if (lat_en) begin
      lat_q  <= lat_d;
      kind_q <= kind_d;
      rail_q <= rail_d;
    end
  end

  assign pwm_off    = lat_q;
  assign pg_ok      = ~lat_q;
  assign fault_kind = kind_q;
  assign fault_rail = rail_q;

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (pwm_off && !clr) |=> pwm_off);

  // R7
  first_fault_keep_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (pwm_off && !clr) |=> ($stable(fault_kind) && $stable(fault_rail)));

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    clr |=> (!pwm_off && fault_kind == 2'd0));

  // R6
  kind_valid_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    pwm_off |-> (fault_kind != 2'd0));
endmodule

// File: tb/rail_fault_latch_tb.sv
`timescale 1ns/1ps
module rail_fault_latch_tb;
  localparam int OV  = 3;
  localparam int UV  = 5;
  localparam int OC  = 7;
  localparam int BLK = 10;

  logic       clk = 1'b0;
  logic       rst_n, supply_on, clr;
  logic [3:0] ov_flag, uv_flag, oc_flag;
  logic       pwm_off, pg_ok;
  logic [1:0] fault_kind;
  logic [1:0] fault_rail;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rail_fault_latch #(.N_RAILS(4), .OV_DLY(OV), .UV_DLY(UV), .OC_DLY(OC), .BLANK_DLY(BLK)) u_dut (
    .clk (clk), .rst_n (rst_n), .supply_on (supply_on), .clr (clr),
    .ov_flag (ov_flag), .uv_flag (uv_flag), .oc_flag (oc_flag),
    .pwm_off (pwm_off), .pg_ok (pg_ok), .fault_kind (fault_kind), .fault_rail (fault_rail)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int dly(input int k);
    return (k == 1) ? OV : (k == 2) ? UV : OC;
  endfunction

  task automatic set_flag(input int k, input int r, input logic v);
    case (k)
      1: ov_flag[r] = v;
      2: uv_flag[r] = v;
      default: oc_flag[r] = v;
    endcase
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R9", "pwm_off after clr", int'(pwm_off), 0);
    chk("R9", "kind after clr", int'(fault_kind), 0);
  endtask

  initial begin
    rst_n = 1'b0; supply_on = 1'b0; clr = 1'b0;
    ov_flag = '0; uv_flag = '0; oc_flag = '0;
    wait_n(3);
    chk("R1", "pwm_off in reset", int'(pwm_off), 0);
    chk("R1", "pg_ok in reset", int'(pg_ok), 1);
    chk("R1", "kind in reset", int'(fault_kind), 0);
    chk("R1", "rail in reset", int'(fault_rail), 0);
    rst_n = 1'b1; supply_on = 1'b1;
    wait_n(BLK + 8);
    chk("R1", "no fault after start", int'(pwm_off), 0);

    // exact qualification sweep: R2 (OV), R3 (UV), R4 (OC), every rail
    for (int k = 1; k <= 3; k++) begin
      for (int r = 0; r < 4; r++) begin
        string rq;
        rq = (k == 1) ? "R2" : (k == 2) ? "R3" : "R4";
        set_flag(k, r, 1'b1);
        wait_n(dly(k));
        chk(rq, "not yet latched", int'(pwm_off), 0);
        set_flag(k, r, 1'b0);
        wait_n(1);
        chk(rq, "latched", int'(pwm_off), 1);
        chk("R6", "pg_ok low", int'(pg_ok), 0);
        chk("R6", "kind code", int'(fault_kind), k);
        chk("R6", "rail index", int'(fault_rail), r);
        wait_n(3);
        chk("R6", "latch holds", int'(pwm_off), 1);
        do_clear();
      end
    end

    // short runs restart qualification: R5
    for (int k = 1; k <= 3; k++) begin
      for (int r = 0; r < 4; r++) begin
        set_flag(k, r, 1'b1); wait_n(dly(k) - 1);
        set_flag(k, r, 1'b0); wait_n(1);
        set_flag(k, r, 1'b1); wait_n(dly(k) - 1);
        set_flag(k, r, 1'b0); wait_n(3);
        chk("R5", "short runs ignored", int'(pwm_off), 0);
      end
    end

    // first fault kept, clear dominance and re-latch: R7, R9
    ov_flag[2] = 1'b1;
    wait_n(OV + 1);
    chk("R7", "first kind", int'(fault_kind), 1);
    oc_flag[0] = 1'b1;
    wait_n(OC + 3);
    chk("R7", "kind kept", int'(fault_kind), 1);
    chk("R7", "rail kept", int'(fault_rail), 2);
    ov_flag[2] = 1'b0;
    clr = 1'b1;
    wait_n(1);
    chk("R9", "clr beats qualified OC", int'(pwm_off), 0);
    clr = 1'b0;
    wait_n(1);
    chk("R9", "re-latch after clr", int'(pwm_off), 1);
    chk("R9", "re-latch kind", int'(fault_kind), 3);
    chk("R9", "re-latch rail", int'(fault_rail), 0);
    oc_flag[0] = 1'b0;
    wait_n(1);
    do_clear();

    // priority: R8
    uv_flag[3] = 1'b1; wait_n(UV - OV);
    ov_flag[1] = 1'b1; wait_n(OV + 1);
    chk("R8", "OV over UV kind", int'(fault_kind), 1);
    chk("R8", "OV over UV rail", int'(fault_rail), 1);
    uv_flag = '0; ov_flag = '0; wait_n(1); do_clear();

    ov_flag[3] = 1'b1; ov_flag[1] = 1'b1; wait_n(OV + 1);
    chk("R8", "low rail wins", int'(fault_rail), 1);
    ov_flag = '0; wait_n(1); do_clear();

    oc_flag[0] = 1'b1; wait_n(OC - UV);
    uv_flag[2] = 1'b1; wait_n(UV + 1);
    chk("R8", "UV over OC kind", int'(fault_kind), 2);
    chk("R8", "UV over OC rail", int'(fault_rail), 2);
    oc_flag = '0; uv_flag = '0; wait_n(1); do_clear();

    // supply off: R10
    supply_on = 1'b0;
    uv_flag[1] = 1'b1; oc_flag[2] = 1'b1;
    wait_n(OC + 5);
    chk("R10", "UV/OC ignored while off", int'(pwm_off), 0);
    ov_flag[3] = 1'b1;
    wait_n(OV + 1);
    chk("R10", "OV active while off", int'(pwm_off), 1);
    chk("R10", "OV kind while off", int'(fault_kind), 1);
    chk("R10", "OV rail while off", int'(fault_rail), 3);
    ov_flag = '0; wait_n(1); do_clear();

    // start-up blanking: R11
    supply_on = 1'b1;
    wait_n(BLK + UV + 1);
    chk("R11", "still blanked", int'(pwm_off), 0);
    wait_n(1);
    chk("R11", "UV after window", int'(pwm_off), 1);
    chk("R11", "UV kind", int'(fault_kind), 2);
    chk("R11", "UV rail", int'(fault_rail), 1);
    uv_flag = '0; oc_flag = '0; wait_n(1); do_clear();

    // window restart: R12
    supply_on = 1'b0; wait_n(2);
    supply_on = 1'b1; wait_n(6);
    supply_on = 1'b0; wait_n(1);
    supply_on = 1'b1; uv_flag[0] = 1'b1;
    wait_n(BLK + UV + 1);
    chk("R12", "window restarted", int'(pwm_off), 0);
    wait_n(1);
    chk("R12", "UV after restarted window", int'(pwm_off), 1);
    chk("R12", "UV rail", int'(fault_rail), 0);
    uv_flag = '0; wait_n(1); do_clear();

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule